// File: doc/BRIEF.md
# Synchronous JK-Programmed Modulo Counter

This block counts clock edges modulo 3, 4 or 5 using three explicit JK storage cells that all share one clock. No cell holds a plain binary value fed by an adder. Each cell receives a two-bit instruction on every cycle: hold, clear, set or toggle. A small steering network computes that instruction from the outputs of the partner cells, and the modulus picks the steering. Because every cell changes on the same rising edge, a decoder placed on the stage outputs sees only clean transitions.

The modulus is sampled from `mode` while `rst` is high and then stays fixed until the next reset. The counter visits its codes in a fixed order. The cycles are:
- DIV3 walk: 0 → 1 → 2 → 0.
- DIV4 walk: 0 → 1 → 2 → 3 → 0.
- DIV5 walk: 0 → 1 → 2 → 3 → 4 → 0.

The only other transitions are the return transitions, which take any unused code back into its walk. The wrap transition from the last code to 0 raises `tc` for one cycle. The mode register holds four named values: DIV3, DIV4, DIV5 and DIV5_ALT.

Top module: `jkc_modcount`

## Requirements
- R1: On a rising edge with `rst` high, every stage goes to 0 and `tc` goes low. The value on `mode` is captured as the modulus. The reset works whatever value the count had before it.
- R2: Each cell obeys its instruction {J,K} on the rising edge: 00 holds, 01 clears, 10 sets, 11 inverts.
- R3: With captured mode 00 (DIV3), `q` steps 0,1,2,0,... on successive edges. Bit 0 is the first cell, bit 1 the second, and bit 2 stays 0.
- R4: With captured mode 01 (DIV4), `q` steps 0,1,2,3,0,... and bit 2 stays 0.
- R5: With captured mode 10 (DIV5) or 11 (DIV5_ALT), `q` steps 0,1,2,3,4,0,...
- R6: `tc` is high for exactly the one cycle in which `q` has just wrapped from modulus−1 to 0. It stays low in the cycle after reset.
- R7: A change on `mode` while `rst` is low leaves the count sequence unchanged. The new modulus applies only after a reset edge.
- R8: `q` never leaves 0..modulus−1. The steering returns any code outside the walk into the walk on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for all cells, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also captures `mode` |
| mode | input | 2 | Modulus select: 00 = 3, 01 = 4, 10/11 = 5 |
| q | output | STAGES (3) | Individual cell outputs, bit 0 = first cell |
| tc | output | 1 | One-cycle pulse when the count wraps to 0 |

## Verification
The bench runs each of the four mode codes for more than two full walks. This tells apart the 3-, 4- and 5-step sequences and shows that codes 10 and 11 behave alike. A reset applied in the middle of a walk separates the reset clear from the natural wrap, and so checks that `tc` stays low after reset. Moving `mode` during a run without a reset, and then applying a reset, tells apart a design that samples the mode continuously from one that samples it only at reset.

// File: rtl/jkc_pkg.sv
package jkc_pkg;

    // Instruction code presented to a cell, bit 1 = J, bit 0 = K
    typedef enum logic [1:0] {
        JK_HOLD = 2'b00,
        JK_CLR  = 2'b01,
        JK_SET  = 2'b10,
        JK_TOG  = 2'b11
    } jk_e;

    // Captured counting mode
    typedef enum logic [1:0] {
        DIV3     = 2'b00,
        DIV4     = 2'b01,
        DIV5     = 2'b10,
        DIV5_ALT = 2'b11
    } mode_e;

    function automatic int modulus_of(mode_e m);
        unique case (m)
            DIV3:          return 3;
            DIV4:          return 4;
            DIV5, DIV5_ALT: return 5;
        endcase
    endfunction

endpackage

// File: rtl/jkc_cell.sv
module jkc_cell
    import jkc_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  jk_e  code,
    output logic q
);

    always_ff @(posedge clk) begin
        if (clr) begin
            q <= 1'b0;
        end else begin
            unique case (code)
                JK_HOLD: q <= q;
                JK_CLR:  q <= 1'b0;
                JK_SET:  q <= 1'b1;
                JK_TOG:  q <= ~q;
            endcase
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (clr)
        (code == JK_HOLD) |=> $stable(q));
    assert_clear_R2: assert property (@(posedge clk) disable iff (clr)
        (code == JK_CLR) |=> (q == 1'b0));
    assert_set_R2: assert property (@(posedge clk) disable iff (clr)
        (code == JK_SET) |=> (q == 1'b1));
    assert_toggle_R2: assert property (@(posedge clk) disable iff (clr)
        (code == JK_TOG) |=> (q != $past(q)));

endmodule

// File: rtl/jkc_steer.sv
module jkc_steer
    import jkc_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  mode_e             mode,
    input  logic [STAGES-1:0] q,
    output jk_e               code [STAGES]
);

    logic [STAGES-1:0] j_in;
    logic [STAGES-1:0] k_in;

    always_comb begin
        // unused cells are held cleared
        j_in = '0;
        k_in = '1;
        unique case (mode)
            DIV3: begin
                j_in[0] = ~q[1];
                k_in[0] = 1'b1;
                j_in[1] = q[0];
                k_in[1] = 1'b1;
            end
            DIV4: begin
                j_in[0] = 1'b1;
                k_in[0] = 1'b1;
                j_in[1] = q[0];
                k_in[1] = q[0];
            end
            DIV5, DIV5_ALT: begin
                j_in[0] = ~q[2];
                k_in[0] = 1'b1;
                j_in[1] = q[0];
                k_in[1] = q[0];
                j_in[2] = q[0] & q[1];
                k_in[2] = 1'b1;
            end
        endcase
    end

    for (genvar i = 0; i < STAGES; i++) begin : g_code
        assign code[i] = jk_e'({j_in[i], k_in[i]});
    end

endmodule

// File: rtl/jkc_modcount.sv
module jkc_modcount
    import jkc_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    output logic [STAGES-1:0] q,
    output logic              tc
);

    mode_e             mode_q;
    jk_e               code [STAGES];
    logic [STAGES-1:0] last_val;
    int                mod_now;

    // captured mode register
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= mode_e'(mode);
        end
    end

    jkc_steer #(.STAGES(STAGES)) u_steer (
        .mode (mode_q),
        .q    (q),
        .code (code)
    );

    for (genvar i = 0; i < STAGES; i++) begin : g_cell
        jkc_cell u_cell (
            .clk  (clk),
            .clr  (rst),
            .code (code[i]),
            .q    (q[i])
        );
    end

    // output process: wrap pulse
    always_comb begin
        mod_now  = modulus_of(mode_q);
        last_val = STAGES'(mod_now - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tc <= 1'b0;
        end else begin
            tc <= (q == last_val);
        end
    end

    assert_in_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        (int'(q) < mod_now));
    assert_recover_R8: assert property (@(posedge clk) disable iff (rst)
        (int'(q) >= mod_now) |=> (int'(q) < mod_now));
    assert_tc_single_R6: assert property (@(posedge clk) disable iff (rst)
        tc |=> !tc);
    assert_tc_zero_R6: assert property (@(posedge clk) disable iff (rst)
        tc |-> (q == '0));
    assert_mode_held_R7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mode_q));

endmodule

// File: tb/jkc_modcount_test.sv
module jkc_modcount_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic [2:0] q;
    logic       tc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference
    int ref_cnt = 0;
    int ref_mod = 3;
    bit ref_tc = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jkc_modcount #(.STAGES(3)) uut (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .q    (q),
        .tc   (tc)
    );

    function automatic int mod_from(logic [1:0] m);
        if (m == 2'b00) return 3;
        if (m == 2'b01) return 4;
        return 5;
    endfunction

    function automatic string seq_tag(int m);
        if (m == 3) return "R3";
        if (m == 4) return "R4";
        return "R5";
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at negedge, model at posedge, compare at next negedge
    task automatic step(input logic r, input logic [1:0] m, input string extra);
        rst  = r;
        mode = m;
        @(posedge clk);
        if (r) begin
            ref_cnt = 0;
            ref_tc  = 1'b0;
            ref_mod = mod_from(m);
        end else begin
            ref_tc  = (ref_cnt == ref_mod - 1);
            ref_cnt = (ref_cnt + 1) % ref_mod;
        end
        @(negedge clk);
        if (r) begin
            chk("R1 reset q", int'(q), 0);
            chk("R1 reset tc", int'(tc), 0);
        end else begin
            chk({seq_tag(ref_mod), " R2 sequence ", extra}, int'(q), ref_cnt);
            chk({"R6 tc ", extra}, int'(tc), int'(ref_tc));
            chk("R8 in range", int'(int'(q) < ref_mod), 1);
        end
    endtask

    initial begin
        @(negedge clk);
        // mode 00
        step(1'b1, 2'b00, "");
        step(1'b1, 2'b00, "");
        for (int i = 0; i < 9; i++) step(1'b0, 2'b00, "");
        // mode 01, reset in the middle of a walk first
        for (int i = 0; i < 2; i++) step(1'b0, 2'b00, "");
        step(1'b1, 2'b01, "");
        for (int i = 0; i < 10; i++) step(1'b0, 2'b01, "");
        // reset mid-walk (R1)
        step(1'b1, 2'b01, "");
        for (int i = 0; i < 5; i++) step(1'b0, 2'b01, "");
        // mode 10
        step(1'b1, 2'b10, "");
        for (int i = 0; i < 12; i++) step(1'b0, 2'b10, "");
        // mode 11
        step(1'b1, 2'b11, "");
        for (int i = 0; i < 11; i++) step(1'b0, 2'b11, "");
        // R7: mode moves without reset, modulus must stay 5
        step(1'b1, 2'b10, "");
        for (int i = 0; i < 8; i++) step(1'b0, 2'b00, "R7 no reset");
        for (int i = 0; i < 4; i++) step(1'b0, 2'b01, "R7 no reset");
        // R7: new modulus after reset
        step(1'b1, 2'b00, "");
        for (int i = 0; i < 7; i++) step(1'b0, 2'b01, "R7 after reset");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule